// File: doc/BRIEF.md
# Hold-Based CIC Interpolator

This block raises the sample rate of a signed fixed-point stream by an integer factor using a cascaded integrator-comb structure with unit differential delay. The innermost comb, zero insertion and integrator are folded into one zero-order hold, which repeats each incoming sample for the full output period. The other combs work at the low input rate before the hold. The other integrators work at the high output rate after it. Because of this, the block needs one comb and one integrator fewer than the textbook cascade, and its output is still the same.

A two-state sequencer decides when the hold takes a new sample. In ST_IDLE there is no sample to repeat. The input is offered ready and no outputs are produced. An accepted sample moves the sequencer to ST_HOLD, where a repeat counter runs from 0 to RATE-1 and one output is made per cycle. At the last repeat the input is again offered ready. If a sample arrives then, the sequencer stays in ST_HOLD and the counter restarts. If not, it returns to ST_IDLE and the output stream pauses without losing state. With continuous input, one sample is taken every RATE cycles and out_valid stays high all the time.

All internal arithmetic is two's complement at the final output width and wraps at that width. This is exact because the true filter output always fits in that width. Output scaling and rounding are left to the consumer.

Top module: `cic_hold_interp`

## Requirements
- R1: A synchronous active-high reset leaves in_ready at 1, out_valid at 0 and out_data at 0.
- R2: in_ready is 1 in ST_IDLE. In ST_HOLD it is 1 only on the last of the RATE repeats, and it is 0 in the cycle right after an accepted sample. With input always offered, accepted samples are exactly RATE cycles apart.
- R3: Each accepted sample yields exactly RATE valid outputs. The first of these appears in the second cycle after the acceptance edge.
- R4: The k-th valid output (counting from 0 after reset) equals y[k-(STAGES-2)], or 0 when that index is negative. Here y is formed by inserting RATE-1 zeros after each input sample and then applying STAGES cascaded RATE-tap running sums.
- R5: A constant input x settles to a constant output of x * RATE^(STAGES-1).
- R6: out_data is IN_W + (STAGES-1)*log2(RATE) bits wide (12 bits for 8-bit input, RATE 4, 3 stages). A full-scale input of -128 held constant gives exactly -2048, and alternating extremes give exact results.
- R7: If no sample is offered at the last repeat, the sequencer returns to ST_IDLE and out_valid drops. When samples resume, the sequence of valid outputs is identical to the one from a gap-free stream of the same samples.
- R8: While out_valid is 0, out_data does not change.
- R9: in_data has no effect on the outputs in cycles where in_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at the high (output) rate |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block takes the offered sample at this edge |
| in_data | input | IN_W | Signed input sample (default 8 bits: sign, 3 integer, 4 fraction) |
| out_valid | output | 1 | out_data holds a new high-rate sample |
| out_data | output | OUT_W | Signed interpolated sample, IN_W + (STAGES-1)*log2(RATE) bits |

## Verification
Each stage here keeps state forever: the comb registers hold the last low-rate sample, and the integrators accumulate without end. A single wrong value in any of them therefore shows up on the first valid output after it, as a mismatch against the zero-stuffed running-sum model, and the error stays in every output that follows. A counter or state fault shows at the ports within one output period instead. It appears as a ready pulse that is not spaced RATE cycles apart, as more or fewer than RATE valid outputs for each accepted sample, or as out_valid staying high after the input has been starved. The bench covers both kinds of fault. It compares every valid output, and it separately times the handshake and the valid bursts against the acceptance edges.

// File: rtl/cic_hold_pkg.sv
package cic_hold_pkg;

    // Sequencer states: nothing to repeat, or repeating the held sample.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } hold_state_t;

endpackage

// File: rtl/cic_hold_seq.sv
module cic_hold_seq
    import cic_hold_pkg::*;
#(
    parameter int RATE  = 4,
    parameter int CNT_W = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    output logic take,
    output logic step,
    output logic idle
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(RATE - 1);

    hold_state_t      state_q, state_d;
    logic [CNT_W-1:0] rep_q, rep_d;
    logic             last_rep;

    assign last_rep = (rep_q == LAST);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rep_q   <= '0;
        end else begin
            state_q <= state_d;
            rep_q   <= rep_d;
        end
    end

    // Outputs of the current state
    always_comb begin
        in_ready = 1'b0;
        step     = 1'b0;
        idle     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                idle     = 1'b1;
            end
            ST_HOLD: begin
                in_ready = last_rep;
                step     = 1'b1;
            end
        endcase
        take = in_ready && in_valid;
    end

    // Transitions and repeat counter
    always_comb begin
        state_d = state_q;
        rep_d   = rep_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    state_d = ST_HOLD;
                    rep_d   = '0;
                end
            end
            ST_HOLD: begin
                if (!last_rep) begin
                    rep_d = rep_q + CNT_W'(1);
                end else if (take) begin
                    rep_d = '0;
                end else begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

endmodule

// File: rtl/cic_hold_combs.sv
module cic_hold_combs #(
    parameter int W = 12,
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] tap [N+1];

    assign tap[0] = din;

    for (genvar k = 0; k < N; k++) begin : g_comb
        logic [W-1:0] prev_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= '0;
            end else if (en) begin
                prev_q <= tap[k];
            end
        end
        assign tap[k+1] = tap[k] - prev_q;
    end

    assign dout = tap[N];

endmodule

// File: rtl/cic_hold_integs.sv
module cic_hold_integs #(
    parameter int W = 12,
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] acc [N+1];

    assign acc[0] = din;

    for (genvar k = 0; k < N; k++) begin : g_integ
        logic [W-1:0] sum_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                sum_q <= '0;
            end else if (en) begin
                sum_q <= sum_q + acc[k];
            end
        end
        assign acc[k+1] = sum_q;
    end

    assign dout = acc[N];

endmodule

// File: rtl/cic_hold_interp.sv
module cic_hold_interp #(
    parameter int IN_W   = 8,
    parameter int RATE   = 4,
    parameter int STAGES = 3
) (
    input  logic                                            clk,
    input  logic                                            rst,
    input  logic                                            in_valid,
    output logic                                            in_ready,
    input  logic [IN_W-1:0]                                 in_data,
    output logic                                            out_valid,
    output logic [IN_W+(STAGES-1)*$clog2(RATE)-1:0]         out_data
);

    localparam int RATE_BITS = $clog2(RATE);
    localparam int OUT_W     = IN_W + (STAGES - 1) * RATE_BITS;
    localparam int NSEC      = STAGES - 1;

    logic             take;
    logic             step;
    logic             seq_idle;
    logic [OUT_W-1:0] in_ext;
    logic [OUT_W-1:0] comb_out;
    logic [OUT_W-1:0] hold_q;
    logic [OUT_W-1:0] integ_out;
    logic             valid_q;

    assign in_ext = {{(OUT_W-IN_W){in_data[IN_W-1]}}, in_data};

    cic_hold_seq #(
        .RATE  (RATE),
        .CNT_W (RATE_BITS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .take     (take),
        .step     (step),
        .idle     (seq_idle)
    );

    cic_hold_combs #(
        .W (OUT_W),
        .N (NSEC)
    ) u_combs (
        .clk  (clk),
        .rst  (rst),
        .en   (take),
        .din  (in_ext),
        .dout (comb_out)
    );

    // Zero-order hold standing in for the innermost comb, zero-stuffer and integrator
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (take) begin
            hold_q <= comb_out;
        end
    end

    cic_hold_integs #(
        .W (OUT_W),
        .N (NSEC)
    ) u_integs (
        .clk  (clk),
        .rst  (rst),
        .en   (step),
        .din  (hold_q),
        .dout (integ_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= step;
        end
    end

    assign out_valid = valid_q;
    assign out_data  = integ_out;

endmodule

// File: rtl/cic_hold_interp_chk.sv
module cic_hold_interp_chk #(
    parameter int OUT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data,
    input logic             seq_idle
);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (in_ready && !out_valid && out_data == '0));

    p_gap_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    p_first_output_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> ##1 out_valid);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        seq_idle |=> !out_valid);

    p_output_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

endmodule

bind cic_hold_interp cic_hold_interp_chk #(
    .OUT_W (OUT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .seq_idle  (seq_idle)
);

// File: tb/cic_hold_interp_tb.sv
`timescale 1ns/1ps
module cic_hold_interp_tb;

    localparam int IN_W   = 8;
    localparam int RATE   = 4;
    localparam int STAGES = 3;
    localparam int OUT_W  = IN_W + (STAGES - 1) * $clog2(RATE);
    localparam int LAG    = STAGES - 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [IN_W-1:0]  in_data = '0;
    logic             out_valid;
    logic [OUT_W-1:0] out_data;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit done     = 0;

    int xin    [256];
    int got    [1024];
    int refv   [1024];
    int tmpv   [1024];
    int acc_cyc[256];
    int got_n  = 0;
    bit coll   = 0;
    bit have_prev = 0;
    logic [OUT_W-1:0] prev_out;
    int r8_viol = 0;
    int low_seen = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    cic_hold_interp #(
        .IN_W   (IN_W),
        .RATE   (RATE),
        .STAGES (STAGES)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // Output collector, sampling away from the active edge
    always @(negedge clk) begin
        if (coll) begin
            if (out_valid) begin
                got[got_n] = int'($signed(out_data));
                got_n++;
            end else begin
                low_seen++;
                if (have_prev && out_data != prev_out) r8_viol++;
            end
            prev_out  = out_data;
            have_prev = 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        got_n = 0; r8_viol = 0; low_seen = 0; have_prev = 0;
    endtask

    // Zero-stuff, then STAGES running sums of RATE taps, then the pipeline lag
    task automatic build_ref(input int len);
        int n_out = len * RATE;
        for (int n = 0; n < n_out; n++) tmpv[n] = (n % RATE == 0) ? xin[n / RATE] : 0;
        for (int s = 0; s < STAGES; s++) begin
            for (int n = 0; n < n_out; n++) begin
                int sum = 0;
                for (int j = 0; j < RATE; j++) if (n - j >= 0) sum += tmpv[n - j];
                refv[n] = sum;
            end
            for (int n = 0; n < n_out; n++) tmpv[n] = refv[n];
        end
        for (int k = n_out - 1; k >= 0; k--) refv[k] = (k >= LAG) ? tmpv[k - LAG] : 0;
    endtask

    task automatic drive(input int len, input int gap);
        coll = 1;
        @(negedge clk);
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_data  = xin[i][IN_W-1:0];
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            acc_cyc[i] = cyc;
            for (int g = 0; g < gap; g++) begin
                in_valid = 1'b0;
                in_data  = IN_W'($urandom);
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
    endtask

    task automatic settle_and_compare(input int len, input string req);
        repeat (RATE * (STAGES + 2) + 8) @(negedge clk);
        coll = 0;
        check(got_n == len * RATE, "R3 output count", got_n, len * RATE);
        build_ref(len);
        for (int k = 0; k < len * RATE; k++)
            check(got[k] == refv[k], req, got[k], refv[k]);
    endtask

    task automatic t_reset();
        do_reset();
        rst = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        check(out_data == '0, "R1 data", int'($signed(out_data)), 0);
        rst = 1'b0;
    endtask

    task automatic t_timing();
        int run;
        do_reset();
        @(negedge clk);
        check(in_ready == 1'b1, "R2 ready in idle", int'(in_ready), 1);
        in_valid = 1'b1; in_data = 8'sd5;
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b0, "R2 ready after accept", int'(in_ready), 0);
        check(out_valid == 1'b0, "R3 no output yet", int'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R3 first output", int'(out_valid), 1);
        run = 0;
        while (out_valid && run < 4 * RATE) begin run++; @(negedge clk); end
        check(run == RATE, "R3 burst length", run, RATE);
        check(in_ready == 1'b1, "R2 ready back in idle", int'(in_ready), 1);
        // continuous stream: acceptances spaced RATE apart
        do_reset();
        for (int i = 0; i < 8; i++) xin[i] = i * 3 - 10;
        drive(8, 0);
        for (int i = 1; i < 8; i++)
            check(acc_cyc[i] - acc_cyc[i-1] == RATE, "R2 accept spacing",
                  acc_cyc[i] - acc_cyc[i-1], RATE);
        settle_and_compare(8, "R4 ramp");
    endtask

    task automatic t_impulse();
        do_reset();
        for (int i = 0; i < 6; i++) xin[i] = (i == 0) ? 16 : 0;
        drive(6, 0);
        settle_and_compare(6, "R4 impulse");
    endtask

    task automatic t_dc();
        do_reset();
        for (int i = 0; i < 10; i++) xin[i] = 100;
        drive(10, 0);
        settle_and_compare(10, "R5 dc trace");
        check(got[10 * RATE - 1] == 100 * (RATE ** (STAGES - 1)), "R5 dc gain",
              got[10 * RATE - 1], 100 * (RATE ** (STAGES - 1)));
    endtask

    task automatic t_fullscale();
        do_reset();
        for (int i = 0; i < 10; i++) xin[i] = -128;
        drive(10, 0);
        settle_and_compare(10, "R6 negative full scale");
        check(got[10 * RATE - 1] == -2048, "R6 extreme", got[10 * RATE - 1], -2048);
        do_reset();
        for (int i = 0; i < 12; i++) xin[i] = (i % 2 == 0) ? 127 : -128;
        drive(12, 0);
        settle_and_compare(12, "R6 alternating extremes");
    endtask

    task automatic t_random();
        do_reset();
        for (int i = 0; i < 20; i++) xin[i] = $signed(8'($urandom));
        drive(20, 0);
        settle_and_compare(20, "R4 random");
    endtask

    task automatic t_gaps();
        do_reset();
        for (int i = 0; i < 12; i++) xin[i] = $signed(8'($urandom));
        drive(12, RATE + 1);
        settle_and_compare(12, "R7 starved stream");
        check(low_seen > 0, "R7 valid dropped", low_seen, 1);
        check(r8_viol == 0, "R8 data frozen", r8_viol, 0);
        do_reset();
        for (int i = 0; i < 12; i++) xin[i] = $signed(8'($urandom));
        drive(12, 1);
        settle_and_compare(12, "R9 garbage while invalid");
        check(r8_viol == 0, "R8 data frozen", r8_viol, 0);
    endtask

    initial begin
        t_reset();
        t_timing();
        t_impulse();
        t_dc();
        t_fullscale();
        t_random();
        t_gaps();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        while (cyc < 150000 && !done) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule